// File: doc/BRIEF.md
# DMA Local Bus Ownership Controller

This block decides when a DMA engine holds the local bus and when it lets go. It raises a hold request and waits for the acknowledge. Only then does it allow transfers to proceed. It drops the bus when any one of a set of release causes appears. A cause that shows up partway through a 32-bit word is remembered, and it takes effect only when the word-boundary strobe arrives. An ownership timer starts when the acknowledge arrives. If this timer runs out while its enable is set, the bus is released for a programmable pause, and then the hold request is raised again on its own.

A second, independent part handles the bus request on the PCI side. It raises the request when the engine wants the bus. It drops the request on a FIFO limit, on a lost grant after the PCI latency timer has run out, or on a target disconnect. After dropping, it keeps the request low for a minimum number of clocks before asking again. There is no data stream in this block. Every pin is a plain level control or status signal, sampled on the rising clock edge, so no back-pressure rules apply.

Top module: `lbus_own_ctrl`

## Requirements
- R1: While reset is active and on the first cycle after it, `hold`, `xfer_ok` and `pci_req` are 0.
- R2: If `xfer_req` is high while the bus is not held, `hold` rises one cycle later. `xfer_ok` rises only in the cycle after `holda` is sampled high, and `xfer_ok` never stands without `hold`.
- R3: The FIFO causes a local release only in step with the direction. With `dir_l2p`=1 the cause is `fifo_full`, and with `dir_l2p`=0 it is `fifo_empty`. The other flag has no effect.
- R4: The ownership timer is loaded with `lat_load` when `holda` is accepted, and counts down once per owned cycle. With `lat_en`=1 it releases the bus on its (`lat_load`+1)-th owned cycle, so `xfer_ok` is high for `lat_load`+1 cycles. With `lat_en`=0 it releases nothing.
- R5: `brq_mode` sets how `ext_brq` acts: 0 means ignored, 1 means immediate release, 2 means release only once the ownership timer has reached zero (whether or not `lat_en` is set), and 3 means ignored. A release from this cause leaves `hold` low for one cycle before the bus is requested again.
- R6: A high `slave_pend` releases the bus. A high `eot` releases it only when `eot_en`=1.
- R7: A release waits for a cycle in which `lword_end` is high. A cause seen earlier is held even if it goes away. `hold` and `xfer_ok` stay high up to and including that boundary cycle and are both low in the next cycle.
- R8: A release in which the ownership timer's expiry (with `lat_en`=1) took part keeps `hold` low for `pause_load`+1 cycles. `hold` is then raised again if `xfer_req` is high.
- R9: If `xfer_req` drops while the bus is owned, the bus is released at the next boundary, and `hold` stays low while `xfer_req` stays low.
- R10: `pci_req` drops in the cycle after any of these: `pci_want` low, the FIFO limit for the direction (`fifo_empty` when `dir_l2p`=1, `fifo_full` when `dir_l2p`=0), `pci_lat_exp` high with `pci_gnt` low, or `pci_disc` high. `pci_lat_exp` with `pci_gnt` high has no effect.
- R11: Once `pci_req` has dropped, it stays low for at least `PCI_GAP` cycles (2 by default).
- R12: Once the gap has passed and no PCI release cause is present, `pci_req` rises one cycle after `pci_want` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_req | input | 1 | DMA engine wants the local bus |
| dir_l2p | input | 1 | 1 = local-to-PCI, 0 = PCI-to-local |
| fifo_full | input | 1 | FIFO full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| lat_en | input | 1 | Ownership timer release enable |
| lat_load | input | LAT_W | Ownership timer reload value |
| pause_load | input | PAUSE_W | Pause timer reload value |
| brq_mode | input | 2 | External request handling: 0 ignore, 1 immediate, 2 after timer, 3 ignore |
| ext_brq | input | 1 | Another master requests the local bus |
| slave_pend | input | 1 | Direct slave access pending |
| eot | input | 1 | End of transfer |
| eot_en | input | 1 | End-of-transfer release enable |
| lword_end | input | 1 | Current 32-bit word completes this cycle |
| holda | input | 1 | Local bus hold acknowledge |
| hold | output | 1 | Local bus hold request |
| xfer_ok | output | 1 | Local transfers may proceed |
| pci_want | input | 1 | Engine wants the PCI bus |
| pci_lat_exp | input | 1 | PCI latency timer expired |
| pci_gnt | input | 1 | PCI grant |
| pci_disc | input | 1 | Target disconnect received |
| pci_req | output | 1 | PCI bus request |

## Verification
Each release cause is applied while `lword_end` is held high, and then again while it is held low, with the boundary given later as a single pulse. The first run shows whether the cause works at all. The second shows whether it waits for the boundary and stays latched after the cause goes away. The timer runs are timed by counting owned cycles and cycles with hold low. These counts tell a timer-driven pause (`pause_load`+1 low cycles) apart from a plain release (one low cycle), and they tell the timer-gated external request apart from the immediate one. On the PCI side, disconnect, grant loss with and without expiry, and FIFO flags of the wrong polarity are each followed by a request that is still pending, so that the count of low cycles shows the enforced gap.

// File: rtl/lbus_own_pkg.sv
package lbus_own_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_OWN   = 3'd2,
    ST_DRAIN = 3'd3,
    ST_PAUSE = 3'd4
  } own_st_t;

  typedef enum logic [1:0] {
    BRQ_IGNORE    = 2'd0,
    BRQ_NOW       = 2'd1,
    BRQ_AFTER_LAT = 2'd2,
    BRQ_SPARE     = 2'd3
  } brq_mode_t;

  typedef struct packed {
    logic any;
    logic lat;
  } rel_t;

endpackage

// File: rtl/lbus_down_timer.sv
module lbus_down_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec_en,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec_en && (cnt_q != '0)) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/lbus_rel_eval.sv
module lbus_rel_eval
  import lbus_own_pkg::*;
(
  input  logic       xfer_req,
  input  logic       dir_l2p,
  input  logic       fifo_full,
  input  logic       fifo_empty,
  input  logic       lat_en,
  input  logic       lat_zero,
  input  logic [1:0] brq_mode,
  input  logic       ext_brq,
  input  logic       slave_pend,
  input  logic       eot,
  input  logic       eot_en,
  output rel_t       rel
);
  logic fifo_lim;
  logic brq_hit;

  // The FIFO limit that stops a local burst depends on which way data flows.
  assign fifo_lim = dir_l2p ? fifo_full : fifo_empty;

  always_comb begin
    unique case (brq_mode_t'(brq_mode))
      BRQ_NOW:       brq_hit = ext_brq;
      BRQ_AFTER_LAT: brq_hit = ext_brq && lat_zero;
      default:       brq_hit = 1'b0;
    endcase
  end

  always_comb begin
    rel.lat = lat_en && lat_zero;
    rel.any = !xfer_req || fifo_lim || rel.lat || brq_hit || slave_pend ||
              (eot && eot_en);
  end
endmodule

// File: rtl/pci_req_gap.sv
module pci_req_gap #(
  parameter int GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pci_want,
  input  logic dir_l2p,
  input  logic fifo_full,
  input  logic fifo_empty,
  input  logic pci_lat_exp,
  input  logic pci_gnt,
  input  logic pci_disc,
  output logic pci_req
);
  localparam int GW = $clog2(GAP + 1);

  logic          req_q;
  logic [GW-1:0] gap_q;
  logic          rel;

  // On the PCI side the FIFO limit is the opposite one from the local side.
  assign rel = !pci_want || (dir_l2p ? fifo_empty : fifo_full) ||
               (pci_lat_exp && !pci_gnt) || pci_disc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      gap_q <= '0;
    end else if (req_q) begin
      if (rel) begin
        req_q <= 1'b0;
        gap_q <= GW'(GAP - 1);
      end
    end else if (gap_q != '0) begin
      gap_q <= gap_q - GW'(1);
    end else if (!rel) begin
      req_q <= 1'b1;
    end
  end

  assign pci_req = req_q;
endmodule

// File: rtl/lbus_own_ctrl.sv
module lbus_own_ctrl
  import lbus_own_pkg::*;
#(
  parameter int LAT_W   = 8,
  parameter int PAUSE_W = 8,
  parameter int PCI_GAP = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_req,
  input  logic               dir_l2p,
  input  logic               fifo_full,
  input  logic               fifo_empty,
  input  logic               lat_en,
  input  logic [LAT_W-1:0]   lat_load,
  input  logic [PAUSE_W-1:0] pause_load,
  input  logic [1:0]         brq_mode,
  input  logic               ext_brq,
  input  logic               slave_pend,
  input  logic               eot,
  input  logic               eot_en,
  input  logic               lword_end,
  input  logic               holda,
  output logic               hold,
  output logic               xfer_ok,
  input  logic               pci_want,
  input  logic               pci_lat_exp,
  input  logic               pci_gnt,
  input  logic               pci_disc,
  output logic               pci_req
);
  own_st_t st_q, st_d;
  rel_t    rel;
  logic    lat_zero, pause_zero;
  logic    lat_ld, pause_ld;
  logic    latpend_q;
  logic    owning;

  assign owning = (st_q == ST_OWN) || (st_q == ST_DRAIN);
  assign lat_ld = (st_q == ST_REQ) && holda;

  lbus_down_timer #(.W(LAT_W)) lat_tmr_i (
    .clk(clk), .rst_n(rst_n), .load(lat_ld), .load_val(lat_load),
    .dec_en(owning), .zero(lat_zero)
  );

  lbus_down_timer #(.W(PAUSE_W)) pause_tmr_i (
    .clk(clk), .rst_n(rst_n), .load(pause_ld), .load_val(pause_load),
    .dec_en(st_q == ST_PAUSE), .zero(pause_zero)
  );

  lbus_rel_eval rel_i (
    .xfer_req(xfer_req), .dir_l2p(dir_l2p), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .lat_en(lat_en), .lat_zero(lat_zero),
    .brq_mode(brq_mode), .ext_brq(ext_brq), .slave_pend(slave_pend),
    .eot(eot), .eot_en(eot_en), .rel(rel)
  );

  always_comb begin
    st_d     = st_q;
    pause_ld = 1'b0;
    unique case (st_q)
      ST_IDLE: if (xfer_req) st_d = ST_REQ;
      ST_REQ:  if (holda) st_d = ST_OWN;
      ST_OWN: begin
        if (rel.any) begin
          if (!lword_end) begin
            st_d = ST_DRAIN;
          end else if (rel.lat) begin
            st_d     = ST_PAUSE;
            pause_ld = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_DRAIN: begin
        if (lword_end) begin
          if (latpend_q || rel.lat) begin
            st_d     = ST_PAUSE;
            pause_ld = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_PAUSE: if (pause_zero) st_d = xfer_req ? ST_REQ : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      latpend_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_OWN)        latpend_q <= rel.lat;
      else if (st_q == ST_DRAIN) latpend_q <= latpend_q || rel.lat;
      else                       latpend_q <= 1'b0;
    end
  end

  assign hold    = (st_q == ST_REQ) || owning;
  assign xfer_ok = owning;

  pci_req_gap #(.GAP(PCI_GAP)) pci_i (
    .clk(clk), .rst_n(rst_n), .pci_want(pci_want), .dir_l2p(dir_l2p),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .pci_lat_exp(pci_lat_exp), .pci_gnt(pci_gnt), .pci_disc(pci_disc),
    .pci_req(pci_req)
  );
endmodule

// File: rtl/lbus_own_chk.sv
module lbus_own_chk #(
  parameter int PCI_GAP = 2
) (
  input logic clk,
  input logic rst_n,
  input logic holda,
  input logic hold,
  input logic xfer_ok,
  input logic lword_end,
  input logic pci_disc,
  input logic pci_req
);
  localparam int CW = $clog2(PCI_GAP + 2);
  localparam logic [CW-1:0] CMAX = CW'(PCI_GAP + 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_cnt <= CMAX;
    else if (pci_req)          low_cnt <= '0;
    else if (low_cnt != CMAX)  low_cnt <= low_cnt + CW'(1);
  end

  p_ok_needs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ok |-> hold);

  p_ok_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_ok) |-> $past(holda));

  p_drop_on_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_ok) |-> $past(lword_end));

  p_disc_drops_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req && pci_disc) |=> !pci_req);

  p_req_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_req) |-> (low_cnt >= CW'(PCI_GAP)));
endmodule

bind lbus_own_ctrl lbus_own_chk #(.PCI_GAP(PCI_GAP)) chk_i (.*);

// File: tb/lbus_own_ctrl_tb_top.sv
module lbus_own_ctrl_tb_top;
  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_req = 0, dir_l2p = 1, fifo_full = 0, fifo_empty = 0;
  logic lat_en = 0, ext_brq = 0, slave_pend = 0, eot = 0, eot_en = 0;
  logic lword_end = 1, holda = 0;
  logic [7:0] lat_load = 8'd4, pause_load = 8'd3;
  logic [1:0] brq_mode = 2'd0;
  logic pci_want = 0, pci_lat_exp = 0, pci_gnt = 1, pci_disc = 0;
  logic hold, xfer_ok, pci_req;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lbus_own_ctrl #(.LAT_W(8), .PAUSE_W(8), .PCI_GAP(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .dir_l2p(dir_l2p),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .lat_en(lat_en),
    .lat_load(lat_load), .pause_load(pause_load), .brq_mode(brq_mode),
    .ext_brq(ext_brq), .slave_pend(slave_pend), .eot(eot), .eot_en(eot_en),
    .lword_end(lword_end), .holda(holda), .hold(hold), .xfer_ok(xfer_ok),
    .pci_want(pci_want), .pci_lat_exp(pci_lat_exp), .pci_gnt(pci_gnt),
    .pci_disc(pci_disc), .pci_req(pci_req)
  );

  // The bus arbiter acknowledges one cycle after the request.
  always @(negedge clk) holda <= hold;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_n(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: 0 idle, 1 requesting, 2 owning, 3 finishing word, 4 pausing
  int m_st = 0, m_lat = 0, m_pause = 0, m_gap = 0;
  bit m_latpend = 0, m_req = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_lat = 0; m_pause = 0; m_latpend = 0; m_req = 0; m_gap = 0;
    end else begin
      bit lexp, rl, rany, prel;
      int nst;
      lexp = (m_lat == 0);
      rl   = lat_en && lexp;
      rany = !xfer_req || (dir_l2p ? fifo_full : fifo_empty) || rl || slave_pend ||
             (eot && eot_en) || (brq_mode == 1 && ext_brq) ||
             (brq_mode == 2 && ext_brq && lexp);
      nst = m_st;
      if ((m_st == 2 || m_st == 3) && m_lat > 0) m_lat--;
      case (m_st)
        0: if (xfer_req) nst = 1;
        1: if (holda) begin nst = 2; m_lat = lat_load; end
        2: if (rany) begin
             if (!lword_end) begin nst = 3; m_latpend = rl; end
             else if (rl) begin nst = 4; m_pause = pause_load; end
             else nst = 0;
           end
        3: begin
             m_latpend = m_latpend || rl;
             if (lword_end) begin
               if (m_latpend) begin nst = 4; m_pause = pause_load; end
               else nst = 0;
             end
           end
        default: if (m_pause == 0) nst = xfer_req ? 1 : 0; else m_pause--;
      endcase
      if (nst != 3) m_latpend = 0;
      m_st = nst;
      prel = !pci_want || (dir_l2p ? fifo_empty : fifo_full) ||
             (pci_lat_exp && !pci_gnt) || pci_disc;
      if (m_req) begin
        if (prel) begin m_req = 0; m_gap = GAP - 1; end
      end else if (m_gap > 0) m_gap--;
      else if (!prel) m_req = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 hold vs model", hold, (m_st >= 1 && m_st <= 3));
      chk("R7 xfer_ok vs model", xfer_ok, (m_st == 2 || m_st == 3));
      chk("R11 pci_req vs model", pci_req, m_req);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts owned cycles, then cycles with hold low.
  task automatic measure(output int own_n, output int low_n);
    own_n = 0; low_n = 0;
    for (int i = 0; i < 60 && !xfer_ok; i++) @(negedge clk);
    while (xfer_ok && own_n < 100) begin own_n++; @(negedge clk); end
    while (!hold && low_n < 100) begin low_n++; @(negedge clk); end
  endtask

  task automatic go_idle();
    xfer_req = 0;
    cyc(8);
  endtask

  task automatic acquire();
    xfer_req = 1;
    for (int i = 0; i < 60 && !xfer_ok; i++) @(negedge clk);
  endtask

  initial begin
    int o, l;
    cyc(3);
    chk("R1 hold in reset", hold, 1'b0);
    chk("R1 pci_req in reset", pci_req, 1'b0);
    rst_n = 1;
    cyc(1);
    chk("R1 xfer_ok after reset", xfer_ok, 1'b0);
    chk("R1 hold after reset", hold, 1'b0);

    // R2: handshake timing
    xfer_req = 1;
    cyc(1);
    chk("R2 hold one cycle after request", hold, 1'b1);
    chk("R2 no transfer before ack", xfer_ok, 1'b0);
    cyc(1);
    chk("R2 transfer after ack", xfer_ok, 1'b1);

    // R3: wrong-polarity flag ignored, matching one releases
    dir_l2p = 1; fifo_empty = 1;
    cyc(3);
    chk("R3 empty ignored when local-to-PCI", xfer_ok, 1'b1);
    fifo_full = 1;
    cyc(1);
    chk("R3 full releases when local-to-PCI", xfer_ok, 1'b0);
    fifo_full = 0; fifo_empty = 0;
    go_idle();
    dir_l2p = 0; fifo_full = 1;
    acquire(); cyc(3);
    chk("R3 full ignored when PCI-to-local", xfer_ok, 1'b1);
    fifo_empty = 1;
    cyc(1);
    chk("R3 empty releases when PCI-to-local", hold, 1'b0);
    fifo_full = 0; fifo_empty = 0; dir_l2p = 1;
    go_idle();

    // R4 / R8: timer driven release and pause
    lat_en = 1; lat_load = 8'd5; pause_load = 8'd3;
    xfer_req = 1;
    measure(o, l);
    chk_n("R4 owned cycles with timer", o, 6);
    chk_n("R8 pause length", l, 4);
    measure(o, l);
    chk_n("R8 re-acquire after pause", o, 6);
    go_idle();
    lat_en = 0;
    acquire(); cyc(20);
    chk("R4 timer disabled keeps bus", xfer_ok, 1'b1);
    go_idle();

    // R5: external request modes
    ext_brq = 1; brq_mode = 2'd0;
    acquire(); cyc(10);
    chk("R5 mode 0 ignores request", xfer_ok, 1'b1);
    brq_mode = 2'd3;
    cyc(4);
    chk("R5 mode 3 ignores request", xfer_ok, 1'b1);
    brq_mode = 2'd1;
    cyc(1);
    chk("R5 mode 1 immediate release", xfer_ok, 1'b0);
    go_idle();
    brq_mode = 2'd2; lat_load = 8'd6;
    xfer_req = 1;
    measure(o, l);
    chk_n("R5 mode 2 waits for timer", o, 7);
    chk_n("R5 plain release low time", l, 1);
    go_idle();
    ext_brq = 0; brq_mode = 2'd0;

    // R6: slave pending and end of transfer
    eot = 1; eot_en = 0;
    acquire(); cyc(5);
    chk("R6 eot ignored when disabled", xfer_ok, 1'b1);
    eot_en = 1;
    cyc(1);
    chk("R6 eot releases when enabled", xfer_ok, 1'b0);
    eot = 0; eot_en = 0;
    go_idle();
    acquire(); cyc(2);
    slave_pend = 1;
    cyc(1);
    chk("R6 slave pending releases", hold, 1'b0);
    slave_pend = 0;
    go_idle();

    // R7: release deferred to word boundary, cause latched
    lword_end = 0;
    acquire(); cyc(2);
    slave_pend = 1; cyc(1); slave_pend = 0;
    cyc(3);
    chk("R7 held until boundary", hold, 1'b1);
    chk("R7 transfer continues mid-word", xfer_ok, 1'b1);
    lword_end = 1; cyc(1); lword_end = 0;
    chk("R7 released after boundary", hold, 1'b0);
    cyc(3);
    lword_end = 1;
    go_idle();

    // R8 with deferral: timer expires mid-word
    lword_end = 0; lat_en = 1; lat_load = 8'd2; pause_load = 8'd5;
    acquire(); cyc(6);
    chk("R7 timer release waits for boundary", xfer_ok, 1'b1);
    lword_end = 1;
    cyc(1);
    lat_en = 0;
    l = 0;
    while (!hold && l < 50) begin l++; cyc(1); end
    chk_n("R8 pause after deferred timer release", l, 6);
    go_idle();

    // R9: request withdrawn
    acquire(); cyc(2);
    xfer_req = 0;
    cyc(1);
    chk("R9 withdrawn request releases", hold, 1'b0);
    cyc(5);
    chk("R9 stays released", hold, 1'b0);

    // R10 / R11 / R12: PCI request
    pci_want = 1;
    cyc(1);
    chk("R12 request one cycle after want", pci_req, 1'b1);
    pci_lat_exp = 1;
    cyc(2);
    chk("R10 expiry with grant kept", pci_req, 1'b1);
    pci_gnt = 0;
    cyc(1);
    chk("R10 expiry and lost grant drops", pci_req, 1'b0);
    pci_lat_exp = 0; pci_gnt = 1;
    l = 0;
    while (!pci_req && l < 20) begin l++; cyc(1); end
    chk_n("R11 low cycles after drop", l, GAP);
    pci_disc = 1; cyc(1); pci_disc = 0;
    chk("R10 disconnect drops", pci_req, 1'b0);
    cyc(1);
    chk("R11 still low inside gap", pci_req, 1'b0);
    cyc(1);
    chk("R12 request again after gap", pci_req, 1'b1);
    fifo_full = 1;
    cyc(2);
    chk("R10 full ignored when local-to-PCI", pci_req, 1'b1);
    fifo_empty = 1;
    cyc(1);
    chk("R10 empty drops when local-to-PCI", pci_req, 1'b0);
    fifo_full = 0; fifo_empty = 0;
    pci_want = 0;
    cyc(4);
    chk("R10 no want no request", pci_req, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule